// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

This block is a small timer peripheral for a register bus. A counter advances on ticks taken from the block clock through a power-of-two divider. In up mode the counter climbs to a programmable top value and then wraps to zero. In down mode it falls to zero and then reloads the top value. Each wrap or reload raises a status flag. Any flag whose enable bit is set drives the interrupt line.

Software programs the block through single-cycle register writes and combinational reads. Writing a one to a command bit starts or stops the counter. A one-shot option halts the counter at its first wrap or reload, so it can act as a single delay. Status flags have their own set and clear aliases, so software never has to read, modify and write them.

Register map (byte offsets): 0x00 control, 0x04 command, 0x08 count, 0x0C top, 0x10 interrupt enable, 0x14 flags, 0x18 flag set, 0x1C flag clear.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, top reads 0xFFFF, control reads 0, flags read 0 and `irq` is low.
- R2: Control bits [3:0] hold a divide code c. While running, the counter takes one step every 2^c clock cycles. The first step comes 2^c cycles after the start write.
- R3: With control bit 4 clear (up mode), the counter steps up. A step taken at the top value wraps it to 0 and sets flag bit 0.
- R4: With control bit 4 set (down mode), the counter steps down. A step taken at 0 loads the top value and sets flag bit 1.
- R5: With control bit 5 set (one-shot), the step that would wrap or reload leaves the count at 0, sets the flag and stops the counter. The counter stays at 0 until the next start.
- R6: In the command register, writing bit 0 starts the counter and writing bit 1 stops it. When both bits are written together, stop wins. A stopped counter holds its value.
- R7: A write to the count register loads the counter only while it is stopped. A write while it is running is ignored.
- R8: `irq` is high exactly when some flag bit is set and the same bit of the enable register is set.
- R9: Writing a 1 to a bit of the flag-set register sets that flag. Writing a 1 to a bit of the flag-clear register clears that flag. A clear wins over a hardware event in the same cycle.
- R10: Reads of the command, flag-set and flag-clear registers return 0. Reads of the flag register return the current flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The counting function runs in four configurations: up with no division, up with a divide-by-four code, periodic down, and one-shot down. Comparing the first two shows whether the divider sets the step spacing and the phase after start. Comparing the up and down runs shows whether each direction ends at its own boundary and raises its own flag bit. The one-shot run separates a halt from a reload. Further tests check that a count write during a run is ignored, that a combined start-and-stop command leaves the counter idle, and that a clear arriving on the same cycle as a wrap event wins.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PRE_W = (1 << CODE_W) - 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_FSET = ADDR_W'(5'h18);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(5'h1C);

  logic [CODE_W-1:0] code;
  logic              down, oneshot, running;
  logic [PRE_W-1:0]  pre_cnt;
  logic [CNT_W-1:0]  cnt, top;
  logic [1:0]        ien, flags;

  wire we_ctrl = wr_en && addr == A_CTRL;
  wire we_cmd  = wr_en && addr == A_CMD;
  wire we_cnt  = wr_en && addr == A_CNT;
  wire we_top  = wr_en && addr == A_TOP;
  wire we_ien  = wr_en && addr == A_IEN;
  wire [1:0] fset = (wr_en && addr == A_FSET) ? wdata[1:0] : 2'b00;
  wire [1:0] fclr = (wr_en && addr == A_FCLR) ? wdata[1:0] : 2'b00;
  wire cmd_start = we_cmd && wdata[0];
  wire cmd_stop  = we_cmd && wdata[1];
  wire unused_bits = ^wdata[DATA_W-1:CNT_W];

  logic [PRE_W:0]   pre_bit;
  logic [PRE_W-1:0] pre_mask;
  assign pre_bit  = (PRE_W+1)'(1) << code;
  assign pre_mask = pre_bit[PRE_W-1:0] - PRE_W'(1);

  wire tick   = running && ((pre_cnt & pre_mask) == pre_mask);
  wire at_end = down ? (cnt == '0) : (cnt == top);
  wire evt    = tick && at_end;
  wire [1:0] hw_set = {evt && down, evt && !down};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code    <= '0;
      down    <= 1'b0;
      oneshot <= 1'b0;
      top     <= '1;
      ien     <= 2'b00;
    end else begin
      if (we_ctrl) begin
        code    <= wdata[CODE_W-1:0];
        down    <= wdata[4];
        oneshot <= wdata[5];
      end
      if (we_top) top <= wdata[CNT_W-1:0];
      if (we_ien) ien <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_cnt <= '0;
    end else begin
      if (cmd_stop)               running <= 1'b0;
      else if (cmd_start)         running <= 1'b1;
      else if (evt && oneshot)    running <= 1'b0;
      if (cmd_start)              pre_cnt <= '0;
      else if (running)           pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (we_cnt && !running) cnt <= wdata[CNT_W-1:0];
    else if (tick) begin
      if (at_end)    cnt <= (down && !oneshot) ? top : '0;
      else if (down) cnt <= cnt - CNT_W'(1);
      else           cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 2'b00;
    else        flags <= (flags | hw_set | fset) & ~fclr;
  end

  assign irq = |(flags & ien);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DATA_W'({oneshot, down, 4'(code)});
      A_CNT:   rdata = DATA_W'(cnt);
      A_TOP:   rdata = DATA_W'(top);
      A_IEN:   rdata = DATA_W'(ien);
      A_FLG:   rdata = DATA_W'(flags);
      default: rdata = '0;
    endcase
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !we_cnt) |=> $stable(cnt));
  // R5
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && oneshot && !cmd_start) |=> !running);
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FCLR && wdata[1]) |=> !flags[1]);
  // R4
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && !oneshot && cnt == '0) |=> cnt == $past(top));
  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && cnt == top) |=> cnt == '0);
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [4:0] CTRL = 5'h00, CMD = 5'h04, CNT = 5'h08, TOP = 5'h0C,
                         IEN = 5'h10, FLG = 5'h14, FSET = 5'h18, FCLR = 5'h1C;

  tick_timer u_tick_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                           .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 cnt", CNT, 0);
    rd_chk("R1 top", TOP, 32'hFFFF);
    rd_chk("R1 ctrl", CTRL, 0);
    rd_chk("R1 flags", FLG, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_up;
    wr(TOP, 3); wr(CTRL, 0); wr(CMD, 1);
    edges(3); rd_chk("R3 count to top", CNT, 3);
    rd_chk("R3 no flag yet", FLG, 0);
    edges(1); rd_chk("R3 wrap", CNT, 0);
    rd_chk("R3 overflow flag", FLG, 1);
  endtask

  task automatic t_presc;
    wr(CMD, 2); wr(CNT, 0); wr(FCLR, 3); wr(CTRL, 2); wr(TOP, 32'hFFFF); wr(CMD, 1);
    edges(3); rd_chk("R2 no step before 4", CNT, 0);
    edges(1); rd_chk("R2 first step", CNT, 1);
    edges(4); rd_chk("R2 second step", CNT, 2);
  endtask

  task automatic t_down;
    wr(CMD, 2); wr(FCLR, 3); wr(CNT, 2); wr(TOP, 5); wr(CTRL, 32'h10); wr(CMD, 1);
    edges(2); rd_chk("R4 reach zero", CNT, 0);
    rd_chk("R4 no flag yet", FLG, 0);
    edges(1); rd_chk("R4 reload", CNT, 5);
    rd_chk("R4 underflow flag", FLG, 2);
    edges(1); rd_chk("R4 continue down", CNT, 4);
  endtask

  task automatic t_oneshot;
    wr(CMD, 2); wr(FCLR, 3); wr(CNT, 1); wr(CTRL, 32'h30); wr(CMD, 1);
    edges(1); rd_chk("R5 step", CNT, 0);
    edges(1); rd_chk("R5 held at 0", CNT, 0);
    rd_chk("R5 flag", FLG, 2);
    edges(5); rd_chk("R5 stays stopped", CNT, 0);
    wr(CNT, 7); rd_chk("R5 stopped accepts load", CNT, 7);
  endtask

  task automatic t_irq;
    chk("R8 irq masked", irq, 0);
    wr(IEN, 2); chk("R8 irq on", irq, 1);
    wr(IEN, 1); chk("R8 irq other bit", irq, 0);
    wr(FCLR, 2); rd_chk("R9 clear", FLG, 0);
    wr(FSET, 1); rd_chk("R9 set", FLG, 1);
    chk("R8 irq bit0", irq, 1);
    rd_chk("R10 fset reads 0", FSET, 0);
    rd_chk("R10 fclr reads 0", FCLR, 0);
    rd_chk("R10 cmd reads 0", CMD, 0);
    wr(FCLR, 3); wr(IEN, 0);
  endtask

  task automatic t_cmd;
    wr(CTRL, 0); wr(TOP, 32'hFFFF);
    wr(CMD, 3); edges(3); rd_chk("R6 stop wins", CNT, 7);
    wr(CMD, 1);
    wr(CNT, 32'h500); rd_chk("R7 write while running ignored", CNT, 8);
    wr(CMD, 2); rd_chk("R6 stop", CNT, 9);
    edges(3); rd_chk("R6 hold when stopped", CNT, 9);
  endtask

  task automatic t_clear_race;
    wr(CNT, 0); wr(TOP, 1); wr(FCLR, 3); wr(CMD, 1);
    edges(1);
    wr(FCLR, 1);
    rd_chk("R9 clear wins over event", FLG, 0);
    rd_chk("R3 wrapped", CNT, 0);
    wr(CMD, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset; t_up; t_presc; t_down; t_oneshot; t_irq; t_cmd; t_clear_race;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule